// File: doc/BRIEF.md
# Stop and LED Output Configurator

This block turns two small configuration registers into the drive of a voice-playback chip's indicator and stop outputs. One register sets the active polarity of each of three stop outputs. The other picks steady or flashing LED drive and sets the role of one shared pin: trigger 4 input, LED2 output or STPC output. The sequencer gives the logical state of each stop signal and an LED-enable. The block returns the pin levels, the output-enable of the shared pin, and the trigger 4 level it samples from that pin.

Flashing is paced by a prescaled tick. A static rate input selects the fast or the slow blink, and a static option selects whether the two LEDs blink together or in turns. The register writes take effect from the clock edge that captures them. The flash phase restarts whenever the LEDs are off or steady, so every blink sequence starts with LED1 lit.

Top module: `stopled_outcfg`

## Requirements
- R1: After reset the stop polarity field is 111 and the mode field (data bits 7, 6, 5) is 111. All stop outputs are active low, the LEDs flash, and the shared pin drives LED2.
- R2: A stop-register write latches data bits 2, 1, 0 as the polarity of STPC, STPB, STPA (stop_o[2], [1], [0]). Each output equals its active request when the bit is 0 and the inverse of the request when the bit is 1.
- R3: Data bits 7 to 3 of a stop-register write have no effect on any output.
- R4: Mode bit 5 at 0 makes the shared pin the trigger 4 input: pin_oe is 0, pin_o is 0, and trg4_o follows pin_i. In any output role, trg4_o is 0 and pin_oe is 1.
- R5: With mode bit 5 at 1, mode bit 6 at 1 puts LED2 on pin_o and mode bit 6 at 0 puts the STPC output (stop_o[2]) on pin_o.
- R6: While led_en_i is 0 both LEDs are off whatever the mode, and the flash phase returns to its start.
- R7: With mode bit 7 at 0 and led_en_i at 1, both LEDs are lit steadily.
- R8: With mode bit 7 at 1, the flash phase toggles after every FAST_DIV ticks when rate_fast_i is 1, or after every SLOW_DIV ticks when it is 0. The phase starts at 0 with LED1 lit.
- R9: While flashing, LED2 is the inverse of LED1 when sync_i is 0 and equals LED1 when sync_i is 1.
- R10: Mode data bits 4 to 0 have no effect. A register write changes the outputs from the cycle after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stop_wr_i | input | 1 | Stop-register write strobe |
| mode_wr_i | input | 1 | Mode-register write strobe |
| wr_data_i | input | DATA_W | Write data |
| flash_tick_i | input | 1 | Prescaled flash tick, one cycle wide |
| rate_fast_i | input | 1 | Static rate option: 1 fast, 0 slow |
| sync_i | input | 1 | Static option: 1 LEDs blink together, 0 alternate |
| led_en_i | input | 1 | LED enable from the sequencer |
| stop_act_i | input | 3 | Logical stop requests, bit 2 STPC .. bit 0 STPA |
| pin_i | input | 1 | Level read from the shared pin |
| stop_o | output | 3 | Stop outputs after polarity |
| led1_o | output | 1 | LED1 drive |
| pin_o | output | 1 | Shared-pin output value |
| pin_oe | output | 1 | Shared-pin output-enable |
| trg4_o | output | 1 | Trigger 4 level passed on to the sequencer |

## Verification
The bench goes after the write edge. A design that applied a write one cycle late, or applied it combinationally, would show the wrong stop levels or pin role in the cycle after the strobe. A design that decoded the upper stop bits or the low mode bits would change outputs on writes that must be ignored. A design that left the blink counter running through a disabled or steady period would start the next blink with LED2 lit, or toggle on the wrong tick. The random mix also flips the rate option in the middle of a count, which catches a design whose counter overshoots the limit. A wrong priority between mode bits 5 and 6 would drive a pin that must stay an input.

// File: rtl/stopled_pkg.sv
package stopled_pkg;
    localparam int STOP_W = 3;

    typedef struct packed {
        logic flash;     // 1: LEDs blink, 0: steady
        logic pin_led2;  // pin output role: 1 LED2, 0 STPC
        logic pin_out;   // 1: pin is an output, 0: trigger input
    } mode_t;

    typedef enum logic [1:0] {
        PIN_TRIG = 2'd0,
        PIN_STPC = 2'd1,
        PIN_LED2 = 2'd2
    } pin_fn_t;

    localparam mode_t MODE_RST = '{flash: 1'b1, pin_led2: 1'b1, pin_out: 1'b1};
endpackage

// File: rtl/stopled_regs.sv
module stopled_regs
    import stopled_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_wr_i,
    input  logic                mode_wr_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic [STOP_W-1:0]   stop_pol_o,
    output mode_t               mode_o
);
    typedef struct packed {
        logic [STOP_W-1:0] stop_pol;
        mode_t             mode;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_wr_i) st_d.stop_pol = data_i[STOP_W-1:0];
        if (mode_wr_i) begin
            st_d.mode.flash    = data_i[DATA_W-1];
            st_d.mode.pin_led2 = data_i[DATA_W-2];
            st_d.mode.pin_out  = data_i[DATA_W-3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stop_pol <= '1;
            st_q.mode     <= MODE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign stop_pol_o = st_q.stop_pol;
    assign mode_o     = st_q.mode;

    AST_STOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr_i |=> (stop_pol_o == $past(data_i[STOP_W-1:0]))); // R2
    AST_STOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_wr_i |=> $stable(stop_pol_o)); // R3
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_i |=> $stable(mode_o)); // R10
endmodule

// File: rtl/stopled_flash.sv
module stopled_flash #(
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic fast_i,
    output logic phase_o
);
    localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int CNT_W   = $clog2(MAX_DIV + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } fl_t;

    fl_t fl_d, fl_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = fast_i ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
        fl_d = fl_q;
        if (!run_i) begin
            fl_d.cnt   = '0;
            fl_d.phase = 1'b0;
        end else if (tick_i) begin
            if (fl_q.cnt >= last) begin
                fl_d.cnt   = '0;
                fl_d.phase = ~fl_q.phase;
            end else begin
                fl_d.cnt = fl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign phase_o = fl_q.phase;

    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(phase_o)); // R8
    AST_PHASE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !phase_o); // R6
endmodule

// File: rtl/stopled_outcfg.sv
module stopled_outcfg
    import stopled_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_wr_i,
    input  logic              mode_wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              flash_tick_i,
    input  logic              rate_fast_i,
    input  logic              sync_i,
    input  logic              led_en_i,
    input  logic [2:0]        stop_act_i,
    input  logic              pin_i,
    output logic [2:0]        stop_o,
    output logic              led1_o,
    output logic              pin_o,
    output logic              pin_oe,
    output logic              trg4_o
);
    logic [STOP_W-1:0] stop_pol;
    mode_t             mode;
    logic              phase;
    logic              led2;
    pin_fn_t           pin_fn;

    stopled_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .stop_wr_i(stop_wr_i), .mode_wr_i(mode_wr_i), .data_i(wr_data_i),
        .stop_pol_o(stop_pol), .mode_o(mode)
    );

    stopled_flash #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) flash_i (
        .clk(clk), .rst_n(rst_n),
        .run_i(led_en_i && mode.flash), .tick_i(flash_tick_i),
        .fast_i(rate_fast_i), .phase_o(phase)
    );

    always_comb begin
        for (int i = 0; i < STOP_W; i++)
            stop_o[i] = stop_pol[i] ? ~stop_act_i[i] : stop_act_i[i];

        led1_o = led_en_i && (mode.flash ? ~phase : 1'b1);
        led2   = led_en_i && (mode.flash ? (sync_i ? ~phase : phase) : 1'b1);

        if (!mode.pin_out)     pin_fn = PIN_TRIG;
        else if (mode.pin_led2) pin_fn = PIN_LED2;
        else                   pin_fn = PIN_STPC;

        pin_oe = (pin_fn != PIN_TRIG);
        trg4_o = (pin_fn == PIN_TRIG) ? pin_i : 1'b0;
        case (pin_fn)
            PIN_LED2: pin_o = led2;
            PIN_STPC: pin_o = stop_o[2];
            default:  pin_o = 1'b0;
        endcase
    end

    AST_TRIG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.pin_out |-> (!pin_oe && !pin_o)); // R4
    AST_LED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !led_en_i |-> (!led1_o && !led2)); // R6
    AST_STEADY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (led_en_i && !mode.flash) |-> (led1_o && led2)); // R7
    AST_ALT_BLINK: assert property (@(posedge clk) disable iff (!rst_n)
        (led_en_i && mode.flash && !sync_i) |-> (led1_o != led2)); // R9
    AST_SYNC_BLINK: assert property (@(posedge clk) disable iff (!rst_n)
        (led_en_i && mode.flash && sync_i) |-> (led1_o == led2)); // R9
endmodule

// File: tb/stopled_outcfg_tb.sv
module stopled_outcfg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FAST_DIV   = 1;
    localparam int SLOW_DIV   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_wr_i = 0, mode_wr_i = 0;
    logic [7:0] wr_data_i = '0;
    logic       flash_tick_i = 0, rate_fast_i = 0, sync_i = 0, led_en_i = 0;
    logic [2:0] stop_act_i = '0;
    logic       pin_i = 0;
    logic [2:0] stop_o;
    logic       led1_o, pin_o, pin_oe, trg4_o;

    int n_run = 0, n_fail = 0;

    // reference state
    logic [2:0] m_pol;
    logic       m_flash, m_led2, m_out, m_phase;
    int         m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    stopled_outcfg #(.DATA_W(8), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_wr_i(stop_wr_i), .mode_wr_i(mode_wr_i),
        .wr_data_i(wr_data_i), .flash_tick_i(flash_tick_i), .rate_fast_i(rate_fast_i),
        .sync_i(sync_i), .led_en_i(led_en_i), .stop_act_i(stop_act_i), .pin_i(pin_i),
        .stop_o(stop_o), .led1_o(led1_o), .pin_o(pin_o), .pin_oe(pin_oe), .trg4_o(trg4_o)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_stop();
        return stop_act_i ^ m_pol;
    endfunction

    function automatic logic exp_led1();
        return led_en_i && (m_flash ? !m_phase : 1'b1);
    endfunction

    function automatic logic exp_led2();
        return led_en_i && (m_flash ? (sync_i ? !m_phase : m_phase) : 1'b1);
    endfunction

    task automatic check_all(input string ctx);
        logic [2:0] s;
        s = exp_stop();
        chk({ctx, " R2 stop_o"}, stop_o, s);
        chk({ctx, " R6 R7 R8 led1_o"}, {2'b0, led1_o}, {2'b0, exp_led1()});
        chk({ctx, " R4 pin_oe"}, {2'b0, pin_oe}, {2'b0, m_out});
        chk({ctx, " R4 trg4_o"}, {2'b0, trg4_o}, {2'b0, m_out ? 1'b0 : pin_i});
        chk({ctx, " R5 R9 pin_o"}, {2'b0, pin_o},
            {2'b0, !m_out ? 1'b0 : (m_led2 ? exp_led2() : s[2])});
    endtask

    task automatic model_clock();
        int lim;
        lim = rate_fast_i ? FAST_DIV : SLOW_DIV;
        if (!(led_en_i && m_flash)) begin
            m_cnt = 0; m_phase = 1'b0;
        end else if (flash_tick_i) begin
            if (m_cnt >= lim - 1) begin m_cnt = 0; m_phase = !m_phase; end
            else m_cnt++;
        end
        if (stop_wr_i) m_pol = wr_data_i[2:0];
        if (mode_wr_i) {m_flash, m_led2, m_out} = wr_data_i[7:5];
    endtask

    task automatic step(input string ctx);
        #1 check_all(ctx);
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        m_pol = 3'b111; {m_flash, m_led2, m_out} = 3'b111; m_phase = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        led_en_i = 1'b1;
        step("R1 reset");                // stops active low, pin LED2, flashing
        chk("R1 reset stop_o idle high", stop_o, 3'b111);

        // R3: upper stop bits ignored
        stop_wr_i = 1; wr_data_i = 8'hF8; stop_act_i = 3'b101;
        step("R3 write");
        stop_wr_i = 0; wr_data_i = 8'h07;
        step("R3 after");
        chk("R3 upper bits ignored", stop_o, 3'b101);

        // R10 + R5: STPC role with low mode bits set
        mode_wr_i = 1; wr_data_i = 8'hBF;
        step("R10 write");
        mode_wr_i = 0;
        step("R5 R10 stpc");
        chk("R5 pin carries STPC", {2'b0, pin_o}, {2'b0, stop_o[2]});

        // R4: trigger role, steady LEDs
        mode_wr_i = 1; wr_data_i = 8'h1F;
        step("R4 write");
        mode_wr_i = 0; pin_i = 1;
        step("R4 trig");
        chk("R4 trg4 follows pin", {2'b0, trg4_o}, 3'b001);
        chk("R7 steady led1", {2'b0, led1_o}, 3'b001);

        // R8: slow blink, toggle after SLOW_DIV ticks
        mode_wr_i = 1; wr_data_i = 8'hE0; sync_i = 0; rate_fast_i = 0;
        step("R8 write");
        mode_wr_i = 0; led_en_i = 0;
        step("R6 off");
        led_en_i = 1; flash_tick_i = 1;
        for (int i = 0; i < 6; i++) step("R8 R9 slow");
        rate_fast_i = 1;
        for (int i = 0; i < 6; i++) step("R8 R9 fast");
        flash_tick_i = 0;

        for (int i = 0; i < 4000; i++) begin
            stop_wr_i    = ($urandom % 12) == 0;
            mode_wr_i    = ($urandom % 12) == 0;
            wr_data_i    = 8'($urandom);
            flash_tick_i = ($urandom % 3) == 0;
            led_en_i     = ($urandom % 8) != 0;
            stop_act_i   = 3'($urandom);
            pin_i        = 1'($urandom);
            if (($urandom % 50) == 0) rate_fast_i = !rate_fast_i;
            if (($urandom % 50) == 0) sync_i = !sync_i;
            step("rand");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule